// File: doc/BRIEF.md
# Debug Recovery Command Mailbox

This block is the mailbox a debug probe uses to ask for device recovery: wiping main flash, a full factory restore, holding the CPU in its reset handler for a debugger, or password unlock. The probe writes a command word over a small register interface. The mailbox only latches that word. The command is carried out later, when a boot reset arrives or when the external reset pin is released after a short low pulse.

At execution the block raises exactly one strobe toward the function that does the work, or hands over a password chunk. The flash and password engines are outside this block. They answer through a done/error handshake, and the result is shown in a receive-control register that the probe polls.

A password chunk is delivered only by a data-exchange command issued after a fresh chunk has been written. Each exchange consumes the chunk.

Top module: `dbg_mbox_top`

## Requirements
- R1: Register address 3 always reads 0x002E0000.
- R2: Writing address 0 latches bits [15:0] as the command code and sets a pending flag. Address 0 reads back {pending in bit 31, code in [15:0]}. Address 1 holds a 32-bit data word and reads back what was written. Writes by themselves raise no strobe.
- R3: A pending command runs on the clock edge where `boot_rst` is high. The strobe is visible in the following cycle, for one cycle. The mapping is: code 0x020C sets strobe bit 0 (main-memory erase), 0x020A sets bit 1 (factory reset), 0x0206 sets bit 2 (wait for debug) and 0x030E sets bit 3 (password check).
- R4: If `nrst_n` is low for N sampled clocks and then returns high, the pending command runs on the release edge when N < PULSE_LIM. It does not run when N ≥ PULSE_LIM, and it stays pending in that case.
- R5: A second write to address 0 replaces the pending command. Execution clears the pending flag. A trigger with nothing pending has no effect.
- R6: An unrecognised code produces no strobe. It sets the receive state to error (3) with status 0xE1.
- R7: Code 0x00EE (data exchange) outputs the data word on `pwd_word` with a one-cycle `pwd_valid` and reports done (2), but only if address 1 was written since the last exchange. Otherwise it reports error with status 0xE2 and `pwd_valid` stays low.
- R8: Address 2 reads {status in [15:8], state in [1:0]}, where the states are idle 0, busy 1, done 2 and error 3. A strobed command holds busy until `op_done`. It then moves to done (status 0x00), or to error with status 0xE3 if `op_err` is high. Triggers are ignored while busy and the command stays pending.
- R9: If address 0 is written on the same edge as a trigger, the previously pending command runs and the newly written one stays pending.
- R10: After reset the pending flag, code, data word, strobes and `pwd_valid` are 0, and the state is idle with status 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on address) |
| boot_rst | input | 1 | Boot reset event, triggers execution |
| nrst_n | input | 1 | Reset pin level, low active |
| op_done | input | 1 | Completion from the erase/password stub |
| op_err | input | 1 | Failure qualifier sampled with op_done |
| cmd_strobe | output | 4 | One-hot command strobes |
| pwd_word | output | 32 | Password chunk toward the checker |
| pwd_valid | output | 1 | One-cycle qualifier of pwd_word |

## Verification
The collision of interest is a probe write to the command register on the very edge at which a trigger executes the old command. The bench sets `reg_wr` to address 0 and `boot_rst` in the same cycle. It then expects the old command's strobe, with the new code still pending, and it confirms this by firing a second trigger that must produce the new strobe. A second overlap puts a trigger in a busy cycle, where it must be dropped. The behavioural model in the bench predicts every strobe, every register read and the password output on each clock.

// File: rtl/dbg_mbox_pkg.sv
package dbg_mbox_pkg;

    localparam logic [31:0] MBOX_ID = 32'h002E_0000;

    localparam logic [15:0] CMD_MAIN_ERASE = 16'h020C;
    localparam logic [15:0] CMD_FACTORY    = 16'h020A;
    localparam logic [15:0] CMD_WAIT_DBG   = 16'h0206;
    localparam logic [15:0] CMD_PWD_CHECK  = 16'h030E;
    localparam logic [15:0] CMD_XCHG       = 16'h00EE;

    localparam logic [1:0] A_TXCTL  = 2'd0;
    localparam logic [1:0] A_TXDATA = 2'd1;
    localparam logic [1:0] A_RXCTL  = 2'd2;
    localparam logic [1:0] A_IDENT  = 2'd3;

    localparam logic [7:0] STAT_OK     = 8'h00;
    localparam logic [7:0] STAT_BADCMD = 8'hE1;
    localparam logic [7:0] STAT_NODATA = 8'hE2;
    localparam logic [7:0] STAT_OPFAIL = 8'hE3;

    localparam int NUM_STROBE = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_DONE = 2'd2,
        ST_ERR  = 2'd3
    } mbox_state_e;

    typedef struct packed {
        mbox_state_e state;
        logic [7:0]  status;
    } rx_info_t;

    function automatic logic [NUM_STROBE-1:0] strobe_of(input logic [15:0] c);
        case (c)
            CMD_MAIN_ERASE: strobe_of = 4'b0001;
            CMD_FACTORY:    strobe_of = 4'b0010;
            CMD_WAIT_DBG:   strobe_of = 4'b0100;
            CMD_PWD_CHECK:  strobe_of = 4'b1000;
            default:        strobe_of = 4'b0000;
        endcase
    endfunction

endpackage

// File: rtl/dbg_mbox_regs.sv
module dbg_mbox_regs
    import dbg_mbox_pkg::*;
#(
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] wdata,
    input  logic          fire,
    input  rx_info_t      rx,
    output logic          pend,
    output logic [CW-1:0] code,
    output logic [DW-1:0] data,
    output logic          fresh,
    output logic [DW-1:0] rdata
);
    localparam int PAD_TX = DW - CW - 1;
    localparam int PAD_RX = DW - 16;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend  <= 1'b0;
            code  <= '0;
            data  <= '0;
            fresh <= 1'b0;
        end else begin
            // execution consumes; a same-edge write wins (R9)
            if (fire) pend <= 1'b0;
            if (fire && code == CMD_XCHG) fresh <= 1'b0;
            if (wr_en && addr == A_TXCTL) begin
                pend <= 1'b1;
                code <= wdata[CW-1:0];
            end
            if (wr_en && addr == A_TXDATA) begin
                data  <= wdata;
                fresh <= 1'b1;
            end
        end
    end

    always_comb begin
        case (addr)
            A_TXCTL:  rdata = {pend, {PAD_TX{1'b0}}, code};
            A_TXDATA: rdata = data;
            A_RXCTL:  rdata = {{PAD_RX{1'b0}}, rx.status, 6'b0, rx.state};
            default:  rdata = MBOX_ID;
        endcase
    end
endmodule

// File: rtl/dbg_mbox_pulse.sv
module dbg_mbox_pulse #(
    parameter int PULSE_LIM = 100_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic nrst_n,
    output logic short_rel
);
    localparam int CNTW = $clog2(PULSE_LIM + 1);
    localparam logic [CNTW-1:0] LIM = CNTW'(PULSE_LIM);

    logic [CNTW-1:0] low_cnt;
    logic            prev_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= '0;
            prev_n  <= 1'b1;
        end else begin
            prev_n <= nrst_n;
            if (nrst_n)             low_cnt <= '0;
            else if (low_cnt != LIM) low_cnt <= low_cnt + 1'b1;
        end
    end

    assign short_rel = nrst_n && !prev_n && (low_cnt < LIM);
endmodule

// File: rtl/dbg_mbox_exec.sv
module dbg_mbox_exec
    import dbg_mbox_pkg::*;
#(
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  pend,
    input  logic                  trig,
    input  logic [CW-1:0]         code,
    input  logic                  fresh,
    input  logic [DW-1:0]         data,
    input  logic                  op_done,
    input  logic                  op_err,
    output logic                  fire,
    output logic [NUM_STROBE-1:0] strobe,
    output logic [DW-1:0]         pwd_word,
    output logic                  pwd_valid,
    output rx_info_t              rx
);
    logic [NUM_STROBE-1:0] dec;

    assign dec  = strobe_of(code);
    assign fire = pend && trig && (rx.state != ST_BUSY);

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe    <= '0;
            pwd_valid <= 1'b0;
            pwd_word  <= '0;
            rx        <= '{state: ST_IDLE, status: STAT_OK};
        end else begin
            strobe    <= '0;
            pwd_valid <= 1'b0;
            if (rx.state == ST_BUSY && op_done)
                rx <= op_err ? '{state: ST_ERR,  status: STAT_OPFAIL}
                             : '{state: ST_DONE, status: STAT_OK};
            if (fire) begin
                if (dec != '0) begin
                    strobe <= dec;
                    rx     <= '{state: ST_BUSY, status: STAT_OK};
                end else if (code == CMD_XCHG) begin
                    if (fresh) begin
                        pwd_valid <= 1'b1;
                        pwd_word  <= data;
                        rx        <= '{state: ST_DONE, status: STAT_OK};
                    end else begin
                        rx <= '{state: ST_ERR, status: STAT_NODATA};
                    end
                end else begin
                    rx <= '{state: ST_ERR, status: STAT_BADCMD};
                end
            end
        end
    end
endmodule

// File: rtl/dbg_mbox_top.sv
module dbg_mbox_top
    import dbg_mbox_pkg::*;
#(
    parameter int PULSE_LIM = 100_000_000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        boot_rst,
    input  logic        nrst_n,
    input  logic        op_done,
    input  logic        op_err,
    output logic [3:0]  cmd_strobe,
    output logic [31:0] pwd_word,
    output logic        pwd_valid
);
    localparam int DW = 32;
    localparam int CW = 16;

    logic          pend, fresh, fire, short_rel;
    logic [CW-1:0] code;
    logic [DW-1:0] txd;
    rx_info_t      rx;
    mbox_state_e   rx_state;

    assign rx_state = rx.state;

    dbg_mbox_regs #(.DW(DW), .CW(CW)) i_regs (
        .clk(clk), .rst(rst), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .fire(fire), .rx(rx), .pend(pend), .code(code), .data(txd),
        .fresh(fresh), .rdata(reg_rdata)
    );

    dbg_mbox_pulse #(.PULSE_LIM(PULSE_LIM)) i_pulse (
        .clk(clk), .rst(rst), .nrst_n(nrst_n), .short_rel(short_rel)
    );

    dbg_mbox_exec #(.DW(DW), .CW(CW)) i_exec (
        .clk(clk), .rst(rst), .pend(pend), .trig(boot_rst || short_rel),
        .code(code), .fresh(fresh), .data(txd), .op_done(op_done), .op_err(op_err),
        .fire(fire), .strobe(cmd_strobe), .pwd_word(pwd_word),
        .pwd_valid(pwd_valid), .rx(rx)
    );
endmodule

// File: rtl/dbg_mbox_chk.sv
module dbg_mbox_chk
    import dbg_mbox_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [1:0]  reg_addr,
    input logic [31:0] reg_rdata,
    input logic        boot_rst,
    input logic        short_rel,
    input logic        pend,
    input mbox_state_e st,
    input logic        op_done,
    input logic [3:0]  cmd_strobe,
    input logic        pwd_valid
);
    p_ident_r1: assert property (@(posedge clk) disable iff (rst)
        reg_addr == A_IDENT |-> reg_rdata == MBOX_ID);

    p_onehot_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd_strobe, pwd_valid}));

    p_trigger_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd_strobe != 4'b0 || pwd_valid) |-> $past(boot_rst || short_rel));

    p_pending_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd_strobe != 4'b0 || pwd_valid) |-> $past(pend));

    p_err_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ERR && $past(st) != ST_ERR) |-> (cmd_strobe == 4'b0 && !pwd_valid));

    p_busy_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (st == ST_BUSY && !op_done) |=> st == ST_BUSY);

    p_busy_ignore_r8: assert property (@(posedge clk) disable iff (rst)
        st == ST_BUSY |=> (cmd_strobe == 4'b0 && !pwd_valid));
endmodule

bind dbg_mbox_top dbg_mbox_chk i_chk (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
    .boot_rst(boot_rst), .short_rel(short_rel), .pend(pend), .st(rx_state),
    .op_done(op_done), .cmd_strobe(cmd_strobe), .pwd_valid(pwd_valid)
);

// File: tb/test_dbg_mbox_top.sv
module test_dbg_mbox_top;
    localparam int LIM = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        boot_rst = 1'b0;
    logic        nrst_n = 1'b1;
    logic        op_done = 1'b0;
    logic        op_err = 1'b0;
    logic [3:0]  cmd_strobe;
    logic [31:0] pwd_word;
    logic        pwd_valid;

    int    checks = 0;
    int    fails = 0;
    bit    finished = 1'b0;
    string cur_req = "R10";

    always #5 clk = ~clk;

    dbg_mbox_top #(.PULSE_LIM(LIM)) i_dbg_mbox_top (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .boot_rst(boot_rst),
        .nrst_n(nrst_n), .op_done(op_done), .op_err(op_err),
        .cmd_strobe(cmd_strobe), .pwd_word(pwd_word), .pwd_valid(pwd_valid)
    );

    // behavioural reference
    bit        m_pend, m_fresh, m_prev, m_pv;
    bit [15:0] m_code;
    bit [31:0] m_data, m_pw;
    bit [3:0]  m_stb;
    int        m_st, m_stat, m_cnt;

    always @(posedge clk) begin
        bit fire, shrt;
        if (rst) begin
            m_pend = 0; m_fresh = 0; m_prev = 1; m_pv = 0; m_code = 0;
            m_data = 0; m_pw = 0; m_stb = 0; m_st = 0; m_stat = 0; m_cnt = 0;
        end else begin
            shrt = nrst_n && !m_prev && (m_cnt < LIM);
            fire = m_pend && (boot_rst || shrt) && (m_st != 1);
            m_stb = 0; m_pv = 0;
            if (m_st == 1 && op_done) begin
                m_st = op_err ? 3 : 2; m_stat = op_err ? 'hE3 : 0;
            end
            if (fire) begin
                m_pend = 0;
                if      (m_code == 16'h020C) begin m_stb = 1; m_st = 1; m_stat = 0; end
                else if (m_code == 16'h020A) begin m_stb = 2; m_st = 1; m_stat = 0; end
                else if (m_code == 16'h0206) begin m_stb = 4; m_st = 1; m_stat = 0; end
                else if (m_code == 16'h030E) begin m_stb = 8; m_st = 1; m_stat = 0; end
                else if (m_code == 16'h00EE) begin
                    if (m_fresh) begin m_pv = 1; m_pw = m_data; m_st = 2; m_stat = 0; end
                    else begin m_st = 3; m_stat = 'hE2; end
                    m_fresh = 0;
                end else begin m_st = 3; m_stat = 'hE1; end
            end
            if (reg_wr && reg_addr == 0) begin m_pend = 1; m_code = reg_wdata[15:0]; end
            if (reg_wr && reg_addr == 1) begin m_data = reg_wdata; m_fresh = 1; end
            m_cnt  = nrst_n ? 0 : ((m_cnt >= LIM) ? LIM : m_cnt + 1);
            m_prev = nrst_n;
        end
    end

    function automatic bit [31:0] m_read(input bit [1:0] a);
        case (a)
            2'd0:    return {m_pend, 15'b0, m_code};
            2'd1:    return m_data;
            2'd2:    return {16'b0, m_stat[7:0], 6'b0, m_st[1:0]};
            default: return 32'h002E0000;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input bit [31:0] act, input bit [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        chk(cur_req, "strobe", {28'b0, cmd_strobe}, {28'b0, m_stb});
        chk(cur_req, "pwd_valid", {31'b0, pwd_valid}, {31'b0, m_pv});
        chk(cur_req, "pwd_word", pwd_word, m_pw);
        chk(cur_req, "rdata", reg_rdata, m_read(reg_addr));
    endtask

    task automatic wr(input bit [1:0] a, input bit [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 0; reg_addr = 2'd2;
    endtask

    task automatic rd(input string req, input bit [1:0] a, input bit [31:0] exp);
        reg_addr = a; #1;
        chk(req, "read", reg_rdata, exp);
    endtask

    task automatic boot();
        boot_rst = 1; step(); boot_rst = 0;
    endtask

    task automatic finish_op(input bit err);
        op_done = 1; op_err = err; step(); op_done = 0; op_err = 0;
    endtask

    task automatic nrst_pulse(input int n);
        nrst_n = 0;
        repeat (n) step();
        nrst_n = 1;
        step();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        step();
        cur_req = "R10";
        rd("R10", 2'd0, 32'h0); rd("R10", 2'd1, 32'h0); rd("R10", 2'd2, 32'h0);
        chk("R10", "strobe", {28'b0, cmd_strobe}, 32'h0);
        rd("R1", 2'd3, 32'h002E0000);

        cur_req = "R5";
        boot(); chk("R5", "idle trigger", {28'b0, cmd_strobe}, 32'h0);

        cur_req = "R2";
        wr(2'd0, 32'hFFFF020C);
        rd("R2", 2'd0, 32'h8000020C);
        step(); chk("R2", "no strobe on write", {28'b0, cmd_strobe}, 32'h0);
        cur_req = "R3";
        boot(); chk("R3", "erase strobe", {28'b0, cmd_strobe}, 32'h1);
        rd("R5", 2'd0, 32'h0000020C);
        rd("R8", 2'd2, 32'h00000001);
        cur_req = "R8";
        wr(2'd0, 32'h0000020A);
        boot(); chk("R8", "busy ignores trigger", {28'b0, cmd_strobe}, 32'h0);
        rd("R8", 2'd0, 32'h8000020A);
        repeat (2) step();
        finish_op(0); rd("R8", 2'd2, 32'h00000002);
        cur_req = "R3";
        boot(); chk("R3", "factory strobe", {28'b0, cmd_strobe}, 32'h2);
        finish_op(1); rd("R8", 2'd2, 32'h0000E303);

        cur_req = "R5";
        wr(2'd0, 32'h00000206);
        wr(2'd0, 32'h0000030E);
        cur_req = "R4";
        nrst_pulse(5); chk("R4", "short pulse pwd", {28'b0, cmd_strobe}, 32'h8);
        finish_op(0);

        wr(2'd0, 32'h00000206);
        nrst_pulse(LIM + 5); chk("R4", "long pulse", {28'b0, cmd_strobe}, 32'h0);
        nrst_pulse(LIM); chk("R4", "pulse at limit", {28'b0, cmd_strobe}, 32'h0);
        rd("R4", 2'd0, 32'h80000206);
        nrst_pulse(LIM - 1); chk("R4", "pulse below limit", {28'b0, cmd_strobe}, 32'h4);
        finish_op(0);

        cur_req = "R6";
        wr(2'd0, 32'h00001234);
        boot(); chk("R6", "unknown strobe", {28'b0, cmd_strobe}, 32'h0);
        rd("R6", 2'd2, 32'h0000E103);

        cur_req = "R7";
        wr(2'd0, 32'h000000EE);
        boot(); rd("R7", 2'd2, 32'h0000E203);
        wr(2'd1, 32'hCAFEF00D);
        rd("R2", 2'd1, 32'hCAFEF00D);
        wr(2'd0, 32'h000000EE);
        boot();
        chk("R7", "pwd_valid", {31'b0, pwd_valid}, 32'h1);
        chk("R7", "pwd_word", pwd_word, 32'hCAFEF00D);
        step(); chk("R7", "pwd_valid drop", {31'b0, pwd_valid}, 32'h0);
        wr(2'd0, 32'h000000EE);
        boot(); rd("R7", 2'd2, 32'h0000E203);

        cur_req = "R9";
        wr(2'd0, 32'h0000020C);
        reg_wr = 1; reg_addr = 2'd0; reg_wdata = 32'h0000020A; boot_rst = 1;
        step();
        reg_wr = 0; boot_rst = 0;
        chk("R9", "old command runs", {28'b0, cmd_strobe}, 32'h1);
        rd("R9", 2'd0, 32'h8000020A);
        finish_op(0);
        boot(); chk("R9", "new command kept", {28'b0, cmd_strobe}, 32'h2);
        finish_op(0);
        repeat (3) step();

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL R10 watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule